// File: doc/BRIEF.md
# Generation-Tagged Address Space Tag Allocator

This block gives each task a hardware address space tag when the task is scheduled, so that translations of different processes can share the TLB without a flush on every context switch. A task carries a 64-bit software identifier. Its low `TAG_W` bits are the hardware tag and the bits above them are a generation number. The block keeps one global generation register and a map of which tags are still free in that generation.

On a request the block compares the generation in the presented identifier with the global one. If they agree, the identifier is handed back as it is. If they differ, the block takes the lowest free tag and joins it to the current generation. If no tag is free, the block moves to the next generation and makes every tag free again. The requester gets tag 1 of the new generation, and a flush request pulses so that TLB entries carrying recycled tags are removed. Each request is answered exactly one cycle later, and a new request may be presented every cycle.

Top module: `asid_allocator`

## Requirements
- R1: Parameter `TAG_W` is 8 or 16. In every identifier the low `TAG_W` bits are the tag and bits 63..`TAG_W` are the generation. The low `TAG_W` bits of the global generation are always zero.
- R2: After reset the generation is 2^`TAG_W` (0x100 for `TAG_W`=8), tags 1 through 2^`TAG_W`-1 are free, and `rsp_valid` and `flush_req` are low. The first allocation therefore returns 0x101.
- R3: A request sampled with `req_valid` high at a clock edge gives `rsp_valid` high for exactly the following cycle. No request means no response. Back-to-back requests get back-to-back responses.
- R4: If bits 63..`TAG_W` of `req_asid` equal the global generation, `rsp_asid` equals `req_asid`, no tag is consumed and `flush_req` stays low.
- R5: On a generation mismatch with a free tag left, `rsp_asid` is the current generation OR'd with the lowest-numbered free tag, and that tag becomes used. The tag bits of `req_asid` play no part.
- R6: Tag 0 is never allocated. With `TAG_W`=8 exactly 255 allocations fit in one generation.
- R7: On a mismatch with no free tag, the generation increases by 2^`TAG_W` and all tags become free. The response is the new generation OR'd with tag 1, and `flush_req` is high in that same response cycle only.
- R8: `flush_req` is low in every other cycle, and the generation changes only at a rollover.
- R9: After a rollover, allocation continues from tag 2 upward in the new generation. An identifier from an older generation counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Context-switch request strobe |
| req_asid | input | 64 | Task's stored software identifier |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_asid | output | 64 | Identifier the task must use from now on |
| flush_req | output | 1 | Pulse asking for a full TLB invalidation |

## Verification
The bench first sends identifiers whose generation matches the global one, with assorted tag bits. These must come back unchanged and must not disturb the allocation order, which separates reuse from allocation. It then sends stale identifiers with varied upper bits and tag bits through two full generations. The responses show that tags come out in strictly increasing order from 1, that tag 0 is skipped, and that the incoming tag bits are ignored. The exhausting request in each generation must yield tag 1 of the next generation with a single flush pulse. Requests that carry an old generation after a rollover show that stale identifiers are reallocated, not reused.

// File: rtl/asid_pkg.sv
package asid_pkg;

    localparam int ID_W = 64;

    typedef enum logic [1:0] {
        DEC_IDLE  = 2'd0,
        DEC_REUSE = 2'd1,
        DEC_ALLOC = 2'd2,
        DEC_ROLL  = 2'd3
    } decision_e;

    typedef struct packed {
        logic            valid;
        logic            flush;
        logic [ID_W-1:0] asid;
    } rsp_t;

    function automatic logic [ID_W-1:0] gen_step(input int tag_w);
        return ID_W'(64'd1 << tag_w);
    endfunction

endpackage

// File: rtl/asid_lowest_free.sv
module asid_lowest_free #(
    parameter int N     = 256,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     free_vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/asid_free_map.sv
module asid_free_map #(
    parameter int TAG_W = 8,
    localparam int NTAGS = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [TAG_W-1:0] take_idx,
    input  logic             refill,
    output logic [NTAGS-1:0] free_vec
);
    for (genvar g = 0; g < NTAGS; g++) begin : g_slot
        if (g == 0) begin : g_reserved
            assign free_vec[g] = 1'b0;
        end else begin : g_normal
            logic slot_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q <= 1'b1;
                end else if (refill) begin
                    slot_q <= (g != 1);
                end else if (take && (take_idx == TAG_W'(g))) begin
                    slot_q <= 1'b0;
                end
            end
            assign free_vec[g] = slot_q;
        end
    end
endmodule

// File: rtl/asid_gen_reg.sv
module asid_gen_reg
    import asid_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bump,
    output logic [ID_W-1:0] gen_q,
    output logic [ID_W-1:0] gen_inc
);
    localparam logic [ID_W-1:0] STEP = gen_step(TAG_W);

    assign gen_inc = gen_q + STEP;

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q <= STEP;
        end else if (bump) begin
            gen_q <= gen_inc;
        end
    end
endmodule

// File: rtl/asid_allocator.sv
module asid_allocator
    import asid_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [63:0] req_asid,
    output logic        rsp_valid,
    output logic [63:0] rsp_asid,
    output logic        flush_req
);
    localparam int NTAGS = 1 << TAG_W;

    logic [NTAGS-1:0] free_vec;
    logic             found;
    logic [TAG_W-1:0] low_idx;
    logic [ID_W-1:0]  gen_q;
    logic [ID_W-1:0]  gen_inc;
    logic             gen_match;
    decision_e        dec;
    rsp_t             rsp_d;
    rsp_t             rsp_q;

    asid_lowest_free #(.N(NTAGS), .IDX_W(TAG_W)) u_find (
        .free_vec (free_vec),
        .found    (found),
        .idx      (low_idx)
    );

    asid_free_map #(.TAG_W(TAG_W)) u_map (
        .clk      (clk),
        .rst      (rst),
        .take     (dec == DEC_ALLOC),
        .take_idx (low_idx),
        .refill   (dec == DEC_ROLL),
        .free_vec (free_vec)
    );

    asid_gen_reg #(.TAG_W(TAG_W)) u_gen (
        .clk     (clk),
        .rst     (rst),
        .bump    (dec == DEC_ROLL),
        .gen_q   (gen_q),
        .gen_inc (gen_inc)
    );

    assign gen_match = (req_asid[ID_W-1:TAG_W] == gen_q[ID_W-1:TAG_W]);

    always_comb begin
        if (!req_valid)     dec = DEC_IDLE;
        else if (gen_match) dec = DEC_REUSE;
        else if (found)     dec = DEC_ALLOC;
        else                dec = DEC_ROLL;
    end

    always_comb begin
        rsp_d.valid = req_valid;
        rsp_d.flush = 1'b0;
        rsp_d.asid  = '0;
        unique case (dec)
            DEC_REUSE: rsp_d.asid = req_asid;
            DEC_ALLOC: rsp_d.asid = gen_q | ID_W'(low_idx);
            DEC_ROLL: begin
                rsp_d.asid  = gen_inc | ID_W'(1);
                rsp_d.flush = 1'b1;
            end
            default: rsp_d.asid = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_asid  = rsp_q.asid;
    assign flush_req = rsp_q.flush;
endmodule

// File: rtl/asid_allocator_chk.sv
module asid_allocator_chk #(
    parameter int TAG_W = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [63:0] req_asid,
    input logic        rsp_valid,
    input logic [63:0] rsp_asid,
    input logic        flush_req,
    input logic [63:0] gen_q
);
    localparam logic [63:0] STEP = 64'd1 << TAG_W;

    logic same_gen;
    assign same_gen = (req_asid[63:TAG_W] == gen_q[63:TAG_W]);

    // R1
    initial tag_width_chk: assert (TAG_W == 8 || TAG_W == 16);

    // R1
    gen_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        gen_q[TAG_W-1:0] == '0);

    // R3
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R3
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R4
    reuse_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && same_gen) |=> (rsp_asid == $past(req_asid)) && !flush_req);

    // R5
    alloc_gen_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !same_gen) |=> rsp_asid[63:TAG_W] == gen_q[63:TAG_W]);

    // R6
    no_zero_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !same_gen) |=> rsp_asid[TAG_W-1:0] != '0);

    // R7
    rollover_chk: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> rsp_valid && (rsp_asid[TAG_W-1:0] == 1) && (gen_q == $past(gen_q) + STEP));

    // R8
    gen_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !flush_req |-> $stable(gen_q));
endmodule

bind asid_allocator asid_allocator_chk #(.TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_asid  (req_asid),
    .rsp_valid (rsp_valid),
    .rsp_asid  (rsp_asid),
    .flush_req (flush_req),
    .gen_q     (gen_q)
);

// File: tb/asid_allocator_test.sv
module asid_allocator_test;
    localparam int TAG_W = 8;
    localparam int NTAGS = 1 << TAG_W;
    localparam logic [63:0] STEP = 64'd1 << TAG_W;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_asid = '0;
    logic        rsp_valid;
    logic [63:0] rsp_asid;
    logic        flush_req;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    asid_allocator #(.TAG_W(TAG_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_asid  (req_asid),
        .rsp_valid (rsp_valid),
        .rsp_asid  (rsp_asid),
        .flush_req (flush_req)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one cycle (request or idle), then check the registered response.
    task automatic step(input logic v, input logic [63:0] a, input logic [63:0] exp_asid,
                        input logic exp_flush, input string req);
        req_valid = v;
        req_asid  = a;
        @(posedge clk);
        #2;
        check(req, {63'd0, rsp_valid}, {63'd0, v});
        if (v) check(req, rsp_asid, exp_asid);
        check(req, {63'd0, flush_req}, {63'd0, exp_flush});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Sweep a whole generation: tags 'first'..NTAGS-1, then the rollover.
    task automatic sweep(input logic [63:0] gen, input int first);
        for (int k = first; k < NTAGS; k++) begin
            // R5 R6: stale generation, varied upper and tag bits
            step(1'b1, (64'(k) << 40) ^ 64'(k * 7), gen | 64'(k), 1'b0, "R5 R6 R8 sweep");
        end
        // R7: pool empty, next generation tag 1 with flush
        step(1'b1, 64'hDEAD_0000_0000_00FF, (gen + STEP) | 64'd1, 1'b1, "R7 rollover");
        // R7 R8: flush is a single pulse
        step(1'b0, '0, '0, 1'b0, "R7 pulse end");
    endtask

    initial begin : watchdog
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R2: outputs quiet in reset
        check("R2 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R2 reset flush_req", {63'd0, flush_req}, 64'd0);
        rst = 1'b0;
        // R2 R5 R1: first allocation, input tag bits ignored
        step(1'b1, 64'h0000_0000_0000_00AB, STEP | 64'd1, 1'b0, "R2 R5 R1 first alloc");
        // R4: current generation reused unchanged
        step(1'b1, STEP | 64'h37, STEP | 64'h37, 1'b0, "R4 reuse");
        step(1'b1, STEP | 64'h00, STEP | 64'h00, 1'b0, "R4 reuse tag0 bits");
        // R3: idle cycle produces no response
        step(1'b0, STEP | 64'h02, '0, 1'b0, "R3 idle");
        // R4 R5: reuse consumed nothing, next tag is 2
        step(1'b1, 64'h8000_0000_0000_0000, STEP | 64'd2, 1'b0, "R4 R5 after reuse");
        // R3 R5 R6 R7 R8: rest of first generation, back to back
        sweep(STEP, 3);
        // R9: stale identifier from old generation reallocated from tag 2
        step(1'b1, STEP | 64'h05, (2 * STEP) | 64'd2, 1'b0, "R9 old gen");
        // R4: new generation identifier reused
        step(1'b1, (2 * STEP) | 64'hFF, (2 * STEP) | 64'hFF, 1'b0, "R4 reuse new gen");
        // R9 R7: second generation through its rollover
        sweep(2 * STEP, 3);
        // R9: third generation starts at tag 2
        step(1'b1, '0, (3 * STEP) | 64'd2, 1'b0, "R9 third gen");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule